// File: doc/BRIEF.md
# Flash Data Page-Write Controller

This block models a small byte-addressed nonvolatile data array and the logic that programs it. The array behaves like flash rather than RAM: an erased cell reads as one, and programming can only pull bits to zero. A plain write therefore stores the bitwise AND of the old and new contents. The only way back to ones is an erase, and an erase always covers a whole page.

A host reaches the array through a data port with read and write strobes, and reaches an eight-bit control register through a separate register port. The control register holds an enable for the data array, a write enable, a load-page bit and an auto-erase bit, along with two hardware status flags. While load-page is set, data writes collect in a page-wide staging buffer and nothing is programmed. A data write made with load-page clear merges its byte into that buffer and then starts a program cycle. The address of that final write picks the page that is programmed. If auto-erase is set, the page is first returned to all ones.

Each program cycle is followed by a busy interval of fixed length, and bus accesses are not accepted during it. A low-supply input stops a program cycle from changing the array and sets a sticky error flag. The same input also drives a live write-inhibit status bit.

Top module: `nvpage_ctrl`

## Requirements
- R1: After reset the control register reads 00h, busy is low, and once the array is enabled every byte reads FFh.
- R2: A program cycle without auto-erase stores old AND new in each programmed byte, so FEh followed by 01h reads 00h. No bit ever goes from 0 to 1 without an erase.
- R3: When auto-erase (control bit 6) is set at the start of a program cycle, every byte of the target page becomes FFh before the buffered bytes are ANDed in. Other pages are unchanged.
- R4: While load-page (control bit 5) is set, an accepted data write changes only the staging buffer. The array is unchanged and busy stays low.
- R5: Loading the same buffer offset twice before a program cycle leaves the AND of both values at that offset.
- R6: An accepted data write with load-page clear starts a program cycle on the page of its own address (address bits above the page offset). Staged bytes land at their offsets within that page, whatever page they were loaded through.
- R7: The staging buffer returns to all ones after every program cycle, so the next single-byte write programs only its own byte.
- R8: While data enable (control bit 3) is 0, or code-programming enable (bit 7) is 1, a data read returns 00h and a data write is ignored.
- R9: While write enable (control bit 4) is 0, data writes change neither the buffer nor the array.
- R10: Busy is high for exactly BUSY_CYC cycles, starting the cycle after a program cycle begins. Data reads and writes presented while busy are dropped, and the read data holds.
- R11: A program cycle that starts while lowSupply is high leaves the array unchanged and sets the error flag (bit 2). The flag stays set until software writes the register with bit 2 at 0. Writing bit 2 as 1 does not clear it.
- R12: Bit 0 reads 1 one cycle after lowSupply is low and 0 one cycle after it is high, and bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | input | ADDR_W | Data array byte address |
| memWdata | input | 8 | Data write byte |
| memRd | input | 1 | Data read strobe |
| memWr | input | 1 | Data write strobe |
| memRdata | output | 8 | Registered read data, valid the cycle after an accepted read |
| regWr | input | 1 | Control register write strobe |
| regWdata | input | 8 | Control register write value |
| regRdata | output | 8 | Control register contents |
| lowSupply | input | 1 | High when the supply is below the programming threshold |
| busy | output | 1 | Program cycle in progress; data accesses are dropped |

## Verification
The hardest state to reach from the ports is a page that mixes bytes staged through a different page's addresses, twice-loaded offsets and an erase, all in one program cycle. The stimulus gets there by setting load-page, writing several offsets through one page (one offset twice), clearing load-page and ending with a write to another page, with and without auto-erase. Accesses made during busy are placed on the cycles right after a commit by driving the strobes directly instead of through the idle-waiting tasks. A failed program cycle is produced by raising lowSupply just before a commit.

// File: rtl/nvpage_pkg.sv
package nvpage_pkg;
  localparam int DW = 8;

  // control register bit positions
  localparam int B_CODE  = 7;
  localparam int B_ERASE = 6;
  localparam int B_LOAD  = 5;
  localparam int B_WREN  = 4;
  localparam int B_DEN   = 3;
  localparam int B_ERR   = 2;
  localparam int B_INH   = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic rdGo;     // read the array into the read register
    logic rdBlank;  // read while array is unmapped: return zero
    logic load;     // merge write byte into staging buffer
    logic commit;   // program cycle on the page of the current address
    logic erase;    // erase the page before programming
    logic fail;     // supply too low: leave the array alone
  } strobe_t;
endpackage

// File: rtl/nvpage_ctl.sv
module nvpage_ctl
  import nvpage_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          memRd,
  input  logic          memWr,
  input  logic          regWr,
  input  logic [DW-1:0] regWdata,
  input  logic          lowSupply,
  output logic [DW-1:0] regRdata,
  output logic          busy,
  output strobe_t       strb
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] busyCnt;
  logic codeEn, autoErase, loadPg, wrEn, dataEn, errFlag, inhibit;
  logic accessible, wrGo, rdGo;
  logic unusedWrBits;

  assign unusedWrBits = ^regWdata[1:0];

  always_comb begin
    accessible   = dataEn & ~codeEn;
    busy         = (busyCnt != '0);
    wrGo         = memWr & ~busy & accessible & wrEn;
    rdGo         = memRd & ~memWr & ~busy;
    strb.rdGo    = rdGo & accessible;
    strb.rdBlank = rdGo & ~accessible;
    strb.load    = wrGo;
    strb.commit  = wrGo & ~loadPg;
    strb.erase   = autoErase;
    strb.fail    = lowSupply;
    regRdata     = {codeEn, autoErase, loadPg, wrEn, dataEn, errFlag, 1'b0, inhibit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeEn    <= 1'b0;
      autoErase <= 1'b0;
      loadPg    <= 1'b0;
      wrEn      <= 1'b0;
      dataEn    <= 1'b0;
      errFlag   <= 1'b0;
      inhibit   <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (regWr) begin
        codeEn    <= regWdata[B_CODE];
        autoErase <= regWdata[B_ERASE];
        loadPg    <= regWdata[B_LOAD];
        wrEn      <= regWdata[B_WREN];
        dataEn    <= regWdata[B_DEN];
      end
      // software may only clear; hardware sets on a failed program cycle
      errFlag <= (errFlag & ~(regWr & ~regWdata[B_ERR])) | (strb.commit & lowSupply);
      inhibit <= ~lowSupply;
      if (strb.commit)
        busyCnt <= CNT_W'(BUSY_CYC);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  // R10: a program cycle loads the full busy interval
  a_r10_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (busyCnt == CNT_W'(BUSY_CYC)));

  // R10: busy interval counts down by one each cycle
  a_r10_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != '0) |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R11: error flag survives unless software writes bit 2 as zero
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(regWr && !regWdata[B_ERR])) |=> errFlag);

  // R11: program cycle under low supply raises the flag
  a_r11_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && lowSupply) |=> errFlag);
endmodule

// File: rtl/nvpage_dp.sv
module nvpage_dp
  import nvpage_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [DW-1:0]    cells  [DEPTH];
  logic [DW-1:0]    pbuf   [PAGE_BYTES];
  logic [DW-1:0]    merged [PAGE_BYTES];
  logic [OFF_W-1:0] off;
  logic [PG_W-1:0]  pageSel;
  logic             bufClean;

  assign off     = addr[OFF_W-1:0];
  assign pageSel = addr[ADDR_W-1:OFF_W];

  // staging buffer with the incoming byte ANDed into its lane
  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_lane
    assign merged[k] = (strb.load && off == OFF_W'(k)) ? (pbuf[k] & wdata) : pbuf[k];
  end

  always_comb begin
    bufClean = 1'b1;
    for (int k = 0; k < PAGE_BYTES; k++)
      bufClean = bufClean & (&pbuf[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) cells[j] <= {DW{1'b1}};
      for (int k = 0; k < PAGE_BYTES; k++) pbuf[k] <= {DW{1'b1}};
      rdata <= '0;
    end else begin
      if (strb.commit) begin
        for (int k = 0; k < PAGE_BYTES; k++) pbuf[k] <= {DW{1'b1}};
        if (!strb.fail) begin
          for (int j = 0; j < DEPTH; j++) begin
            if (pageSel == PG_W'(j / PAGE_BYTES))
              cells[j] <= (strb.erase ? {DW{1'b1}} : cells[j]) & merged[j % PAGE_BYTES];
          end
        end
      end else if (strb.load) begin
        pbuf[off] <= merged[off];
      end
      if (strb.rdGo)
        rdata <= cells[addr];
      else if (strb.rdBlank)
        rdata <= '0;
    end
  end

  // R7: buffer is back to all ones after a program cycle
  a_r7_buf_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> bufClean);

  for (genvar j = 0; j < DEPTH; j++) begin : g_cellChk
    // R2: without an erase no bit of a cell rises
    a_r2_no_raise: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.commit && strb.erase) |=> ((cells[j] & ~$past(cells[j])) == '0));
    // R4: cells only move on a program cycle
    a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strb.commit |=> $stable(cells[j]));
  end
endmodule

// File: rtl/nvpage_ctrl.sv
module nvpage_ctrl
  import nvpage_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int PAGE_BYTES = 8,
  parameter int BUSY_CYC   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DW-1:0]     memWdata,
  input  logic              memRd,
  input  logic              memWr,
  output logic [DW-1:0]     memRdata,
  input  logic              regWr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic              lowSupply,
  output logic              busy
);
  strobe_t strb;

  nvpage_ctl #(.BUSY_CYC(BUSY_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr),
    .regWr(regWr), .regWdata(regWdata), .lowSupply(lowSupply),
    .regRdata(regRdata), .busy(busy), .strb(strb)
  );

  nvpage_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(memAddr),
    .wdata(memWdata), .rdata(memRdata)
  );

  // R8: a read of the unmapped array returns zero
  a_r8_blank_read: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memWr && !busy && (!regRdata[B_DEN] || regRdata[B_CODE]))
      |=> (memRdata == '0));

  // R10: read data holds while busy
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(memRdata));
endmodule

// File: tb/nvpage_ctrl_test.sv
module nvpage_ctrl_test;
  localparam int AW = 6, PB = 8, BC = 4, DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic [7:0] memWdata = '0, regWdata = '0;
  logic memRd = 1'b0, memWr = 1'b0, regWr = 1'b0, lowSupply = 1'b0;
  logic [7:0] memRdata, regRdata;
  logic busy;

  int runCnt = 0, failCnt = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] mbuf [PB];
  logic [7:0] ctrlShadow = 8'h00;
  logic [7:0] rd;

  always #10 clk = ~clk;

  nvpage_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .BUSY_CYC(BC)) uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRd(memRd), .memWr(memWr), .memRdata(memRdata), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .lowSupply(lowSupply), .busy(busy)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic setCtrl(logic [7:0] v);
    @(negedge clk);
    regWr = 1'b1; regWdata = v;
    @(negedge clk);
    regWr = 1'b0;
    ctrlShadow = v;
  endtask

  // expected effect of a data write, from the requirements
  task automatic modelWrite(int a, logic [7:0] d);
    int off, base;
    off  = a % PB;
    base = (a / PB) * PB;
    if (ctrlShadow[3] && !ctrlShadow[7] && ctrlShadow[4]) begin
      mbuf[off] = mbuf[off] & d;
      if (!ctrlShadow[5]) begin
        if (!lowSupply)
          for (int i = 0; i < PB; i++)
            mem[base + i] = (ctrlShadow[6] ? 8'hFF : mem[base + i]) & mbuf[i];
        for (int i = 0; i < PB; i++) mbuf[i] = 8'hFF;
      end
    end
  endtask

  task automatic busWrite(int a, logic [7:0] d);
    waitIdle();
    memAddr = AW'(a); memWdata = d; memWr = 1'b1;
    @(negedge clk);
    memWr = 1'b0;
    modelWrite(a, d);
    waitIdle();
  endtask

  task automatic busRead(int a, output logic [7:0] v);
    waitIdle();
    memAddr = AW'(a); memRd = 1'b1;
    @(negedge clk);
    memRd = 1'b0;
    v = memRdata;
  endtask

  task automatic verifyAll(string req);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      busRead(a, v);
      check(req, v, mem[a], $sformatf("array byte %0d", a));
    end
  endtask

  initial begin
    #(20 * 150000);
    failCnt++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d1, d2;
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'hFF;
    for (int i = 0; i < PB; i++) mbuf[i] = 8'hFF;

    repeat (3) @(negedge clk);
    check("R1", regRdata, 8'h00, "control in reset");
    rstN = 1'b1;
    check("R1", {7'd0, busy}, 8'h00, "busy after reset");
    @(negedge clk);
    check("R12", regRdata, 8'h01, "inhibit bit with good supply");

    // R8: array not mapped at reset
    busRead(3, rd);
    check("R8", rd, 8'h00, "read with data enable clear");

    setCtrl(8'h18);
    verifyAll("R1");

    // R2: AND programming, explicit case and a sweep over two pages
    busWrite(16, 8'hFE);
    busWrite(16, 8'h01);
    busRead(16, rd);
    check("R2", rd, 8'h00, "FE then 01");
    for (int a = 0; a < PB; a++) begin
      for (int p = 0; p < 2; p++) begin
        int ad;
        ad = (p == 0) ? a : 24 + a;
        d1 = 8'(ad * 37 + 5);
        d2 = 8'(~(ad * 13));
        busWrite(ad, d1);
        busWrite(ad, d2);
        busRead(ad, rd);
        check("R2", rd, d1 & d2, $sformatf("AND at %0d", ad));
      end
    end

    // R10: busy length and dropped accesses during busy
    busRead(49, rd);
    check("R10", rd, 8'hFF, "baseline read");
    memAddr = AW'(50); memWdata = 8'h00; memWr = 1'b1;
    @(negedge clk);
    memWr = 1'b0;
    modelWrite(50, 8'h00);
    check("R10", {7'd0, busy}, 8'h01, "busy after commit");
    memAddr = AW'(51); memWdata = 8'h00; memWr = 1'b1;
    @(negedge clk);
    n = 1;
    memWr = 1'b0; memAddr = AW'(50); memRd = 1'b1;
    @(negedge clk);
    n = 2;
    memRd = 1'b0;
    check("R10", memRdata, 8'hFF, "read data held during busy");
    while (busy) begin
      @(negedge clk);
      n++;
    end
    check("R10", 8'(n), 8'(BC), "busy cycle count");
    busRead(51, rd);
    check("R10", rd, 8'hFF, "write during busy dropped");
    busRead(50, rd);
    check("R10", rd, 8'h00, "committed byte");

    // R4, R5, R6: staging through page 5, commit on page 2
    setCtrl(8'h38);
    busWrite(41, 8'h0F);
    busWrite(41, 8'h3C);
    busWrite(43, 8'hA5);
    check("R4", {7'd0, busy}, 8'h00, "no busy while loading");
    busRead(41, rd);
    check("R4", rd, 8'hFF, "array untouched by load");
    busRead(43, rd);
    check("R4", rd, 8'hFF, "array untouched by load");
    setCtrl(8'h18);
    busWrite(22, 8'h7E);
    busRead(17, rd);
    check("R5", rd, 8'h0C, "twice-loaded offset");
    busRead(19, rd);
    check("R6", rd, 8'hA5, "staged byte in final page");
    busRead(22, rd);
    check("R6", rd, 8'h7E, "final byte");
    busRead(41, rd);
    check("R6", rd, 8'hFF, "loading page not programmed");

    // R7: buffer cleared, single byte only
    busWrite(20, 8'hF0);
    busRead(20, rd);
    check("R7", rd, 8'hF0, "single byte");
    busRead(17, rd);
    check("R7", rd, 8'h0C, "neighbour unchanged");
    verifyAll("R7");

    // R3: auto-erase, single byte then staged bytes
    setCtrl(8'h58);
    busWrite(2, 8'h5A);
    for (int a = 0; a < 16; a++) begin
      busRead(a, rd);
      check("R3", rd, (a == 2) ? 8'h5A : 8'hFF, $sformatf("erased page byte %0d", a));
    end
    setCtrl(8'h78);
    busWrite(25, 8'h11);
    busWrite(27, 8'h22);
    setCtrl(8'h58);
    busWrite(30, 8'h33);
    for (int a = 24; a < 32; a++) begin
      busRead(a, rd);
      check("R3", rd, (a == 25) ? 8'h11 : (a == 27) ? 8'h22 : (a == 30) ? 8'h33 : 8'hFF,
            $sformatf("erased staged page byte %0d", a));
    end
    verifyAll("R3");

    // R9: write enable clear
    setCtrl(8'h08);
    busWrite(10, 8'h00);
    busRead(10, rd);
    check("R9", rd, 8'hFF, "write ignored");
    setCtrl(8'h28);
    busWrite(9, 8'h00);
    setCtrl(8'h18);
    busWrite(12, 8'h0F);
    busRead(9, rd);
    check("R9", rd, 8'hFF, "load ignored");
    busRead(12, rd);
    check("R9", rd, 8'h0F, "later write");

    // R8: unmapped array
    setCtrl(8'h10);
    busRead(12, rd);
    check("R8", rd, 8'h00, "read with data enable clear");
    busWrite(13, 8'h00);
    setCtrl(8'h98);
    busRead(12, rd);
    check("R8", rd, 8'h00, "read with code enable set");
    busWrite(14, 8'h00);
    setCtrl(8'h18);
    busRead(13, rd);
    check("R8", rd, 8'hFF, "write ignored, data enable clear");
    busRead(14, rd);
    check("R8", rd, 8'hFF, "write ignored, code enable set");

    // R11, R12: low supply
    lowSupply = 1'b1;
    @(negedge clk);
    check("R12", regRdata, 8'h18, "inhibit low, bit 1 zero");
    busWrite(33, 8'h00);
    check("R11", regRdata[2] ? 8'h01 : 8'h00, 8'h01, "error flag set");
    busRead(33, rd);
    check("R11", rd, 8'hFF, "failed cycle left array");
    lowSupply = 1'b0;
    @(negedge clk);
    check("R12", regRdata[0] ? 8'h01 : 8'h00, 8'h01, "inhibit back high");
    setCtrl(8'h1C);
    check("R11", regRdata[2] ? 8'h01 : 8'h00, 8'h01, "writing one keeps flag");
    setCtrl(8'h18);
    check("R11", regRdata, 8'h19, "flag cleared by software");
    busWrite(33, 8'h81);
    busRead(33, rd);
    check("R11", rd, 8'h81, "program after recovery");

    verifyAll("R2");
    summary();
    $finish;
  end
endmodule